// File: doc/BRIEF.md
# Clock Generator Control Register Bank

This block is the configuration store of a clock generator with three PLLs. A simple byte-wide bus writes it and reads it back: an address, write data, a one-cycle write strobe and a combinational read-data port. The stored bits drive control levels for the analog side. These levels cover the PLL enables, the output-divider enables, the spread enables and the PLL3 frequency/spread select. They also cover the per-output buffer enables, the reference output enable and its edge rate, and a 9-bit CPU feedback divider.

Two pieces of hardware policy sit inside the bank. First, a divider enable can never stay set while the PLL that feeds it is off. The bank clears the divider bit in the same write that turns the PLL off, and the bank refuses to set it while that PLL is off. Second, each CPU output can be marked stoppable. A stoppable output loses its effective enable for as long as the active-low stop input is held low. The feedback divider takes its reset value from a frequency-select input. That input is sampled while reset is asserted, and the last sampled value is held once reset is released.

Top module: `ckgen_ctrl_regs`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the registers read back as follows: register 0 reads EFh, register 1 reads C0h, register 2 reads FFh and register 3 reads 28h.
- R2: Register 0 bits 7, 6 and 5 are the PLL1, PLL2 and PLL3 enables, output as pll_en[2], pll_en[1] and pll_en[0]. Register 0 bits 3, 2, 1 and 0 are the CPU, SRC, LCD and DOT divider enables, output as div_en[3:0] in that order. Register 0 bit 4 reads 0.
- R3: The CPU and SRC divider enables are 0 whenever PLL1 is 0. The LCD divider enable is 0 whenever PLL3 is 0. The DOT divider enable is 0 whenever PLL2 is 0. This holds for a write that sets a divider bit while clearing its parent PLL bit. Read-back returns the interlocked value. Turning a PLL back on does not restore its divider bits.
- R4: Register 1 bit 7 is the PLL1 spread enable and bit 6 is the PLL3 spread enable, output as ss_en[1] and ss_en[0]. Bits 5:3 hold the PLL3 select. pll3_fsel carries this select while bit 6 is 1 and carries 0 otherwise. Bits 2:0 read 0.
- R5: Register 2 bits 7 down to 0 are the buffer enables for CPU0, CPU1, CPU2, SRC0, SRC1, SRC2, DOT and LCD. buf_oe has the same bit order.
- R6: Register 3 bits 2, 1 and 0 mark CPU0, CPU1 and CPU2 as stoppable. While cpu_stop_n is 0, the buf_oe bit of each stoppable CPU output is 0. The buf_oe bit of a free-running output follows its register 2 enable.
- R7: Register 3 bit 5 is the REF enable, output as ref_oe. Bits 4:3 hold the REF edge rate: 00 slow, 01 medium, 10 fast. A write of the reserved code 11 leaves the edge rate unchanged. Bits 7:6 read 0.
- R8: The feedback divider fbdiv_n has bit 8 in register 4 bit 0 and bits 7:0 in register 5. Register 4 bits 7:1 read 1. fbdiv_n changes only on a write to register 4 or register 5.
- R9: At reset, fbdiv_n becomes 07Dh if fsel equals FSEL_166 (01b by default) and becomes 064h for any other fsel. fsel is ignored once reset is released.
- R10: Register 6 always reads F3h and register 7 always reads 00h. Writes to these registers have no effect, and neither do writes to reserved bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsel | input | FSEL_W | Frequency select, sampled while in reset |
| cpu_stop_n | input | 1 | Active-low stop for stoppable CPU outputs |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rdata | output | 8 | Read data for addr (combinational) |
| pll_en | output | 3 | PLL1, PLL2, PLL3 enables |
| div_en | output | 4 | CPU, SRC, LCD, DOT divider enables |
| ss_en | output | 2 | PLL1, PLL3 spread enables |
| pll3_fsel | output | 3 | Effective PLL3 select |
| buf_oe | output | 8 | Effective output buffer enables |
| ref_oe | output | 1 | REF output enable |
| ref_slew | output | 2 | REF edge rate |
| fbdiv_n | output | 9 | CPU feedback divider |

## Verification
The bench builds the block with its default parameters: a 3-bit address, a 2-bit frequency select with 01b as the 166 MHz code, and three stoppable CPU outputs. With these values every register is reachable, including the two reserved ones. Both reset values of the divider can be selected by toggling fsel across a reset. The stop gating can be checked with a mix of stoppable and free-running CPU outputs. Each PLL is switched off in turn to show that only its own dividers are cleared. A same-write conflict and a PLL re-enable cover the remaining interlock corners.

// File: rtl/ckgen_pkg.sv
package ckgen_pkg;
  localparam int DW     = 8;
  localparam int NW     = 9;
  localparam int NCPU   = 3;
  localparam int OE_W   = 8;
  localparam int NPLL   = 3;
  localparam int NDIV   = 4;

  localparam logic [NW-1:0] N_DFLT_166  = 9'h07D;
  localparam logic [NW-1:0] N_DFLT_BASE = 9'h064;
  localparam logic [DW-1:0] RSV6_PAT    = 8'hF3;
  localparam logic [DW-1:0] RSV7_PAT    = 8'h00;
  localparam logic [1:0]    SLEW_MED    = 2'b01;
  localparam logic [1:0]    SLEW_RSVD   = 2'b11;

  typedef struct packed {
    logic [NPLL-1:0] pll;    // [2]=PLL1 [1]=PLL2 [0]=PLL3
    logic [NDIV-1:0] div;    // [3]=CPU [2]=SRC [1]=LCD [0]=DOT
    logic [1:0]      ss;     // [1]=PLL1 [0]=PLL3
    logic [2:0]      p3sel;
    logic [OE_W-1:0] boe;
    logic            ref_en;
    logic [1:0]      slew;
    logic [NCPU-1:0] stop;   // [2]=CPU0 [1]=CPU1 [0]=CPU2
    logic [NW-1:0]   n;
  } cfg_t;

  // Mask divider enables by the PLL that feeds each one.
  function automatic logic [NDIV-1:0] div_gate(input logic [NDIV-1:0] div,
                                               input logic [NPLL-1:0] pll);
    return div & {pll[2], pll[2], pll[0], pll[1]};
  endfunction

  function automatic logic [NW-1:0] n_reset(input logic is_166);
    return is_166 ? N_DFLT_166 : N_DFLT_BASE;
  endfunction

  // Reserved edge-rate code keeps the current setting.
  function automatic logic [1:0] slew_pick(input logic [1:0] cur,
                                           input logic [1:0] req);
    return (req == SLEW_RSVD) ? cur : req;
  endfunction
endpackage

// File: rtl/ckgen_regfile.sv
module ckgen_regfile
  import ckgen_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int FSEL_W = 2,
  parameter logic [FSEL_W-1:0] FSEL_166 = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FSEL_W-1:0] fsel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              wr_en,
  output cfg_t              cfg,
  output logic              wr_fbdiv
);
  logic [NPLL-1:0] new_pll;
  assign new_pll  = wdata[7:5];
  assign wr_fbdiv = wr_en && ((int'(addr) == 4) || (int'(addr) == 5));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.pll    <= '1;
      cfg.div    <= '1;
      cfg.ss     <= '1;
      cfg.p3sel  <= '0;
      cfg.boe    <= '1;
      cfg.ref_en <= 1'b1;
      cfg.slew   <= SLEW_MED;
      cfg.stop   <= '0;
      cfg.n      <= n_reset(fsel == FSEL_166);
    end else if (wr_en) begin
      case (int'(addr))
        0: begin
          cfg.pll <= new_pll;
          cfg.div <= div_gate(wdata[3:0], new_pll);
        end
        1: begin
          cfg.ss    <= wdata[7:6];
          cfg.p3sel <= wdata[5:3];
        end
        2: cfg.boe <= wdata;
        3: begin
          cfg.ref_en <= wdata[5];
          cfg.slew   <= slew_pick(cfg.slew, wdata[4:3]);
          cfg.stop   <= wdata[NCPU-1:0];
        end
        4: cfg.n[8]   <= wdata[0];
        5: cfg.n[7:0] <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ckgen_rdmux.sv
module ckgen_rdmux
  import ckgen_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  cfg_t              cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic [DW-1:0]     rdata
);
  always_comb begin
    case (int'(addr))
      0:       rdata = {cfg.pll, 1'b0, cfg.div};
      1:       rdata = {cfg.ss, cfg.p3sel, 3'b000};
      2:       rdata = cfg.boe;
      3:       rdata = {2'b00, cfg.ref_en, cfg.slew, cfg.stop};
      4:       rdata = {7'h7F, cfg.n[8]};
      5:       rdata = cfg.n[7:0];
      6:       rdata = RSV6_PAT;
      default: rdata = RSV7_PAT;
    endcase
  end
endmodule

// File: rtl/ckgen_outgate.sv
module ckgen_outgate
  import ckgen_pkg::*;
(
  input  logic [OE_W-1:0] boe,
  input  logic [NCPU-1:0] stop,
  input  logic            cpu_stop_n,
  output logic [OE_W-1:0] buf_oe
);
  for (genvar k = 0; k < NCPU; k++) begin : g_cpu
    // CPUk sits at boe bit OE_W-1-k and stop bit NCPU-1-k.
    assign buf_oe[OE_W-1-k] = boe[OE_W-1-k] & ~(stop[NCPU-1-k] & ~cpu_stop_n);
  end
  assign buf_oe[OE_W-1-NCPU:0] = boe[OE_W-1-NCPU:0];
endmodule

// File: rtl/ckgen_ctrl_regs.sv
module ckgen_ctrl_regs
  import ckgen_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int FSEL_W = 2,
  parameter logic [FSEL_W-1:0] FSEL_166 = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FSEL_W-1:0] fsel,
  input  logic              cpu_stop_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  output logic [7:0]        rdata,
  output logic [2:0]        pll_en,
  output logic [3:0]        div_en,
  output logic [1:0]        ss_en,
  output logic [2:0]        pll3_fsel,
  output logic [7:0]        buf_oe,
  output logic              ref_oe,
  output logic [1:0]        ref_slew,
  output logic [8:0]        fbdiv_n
);
  cfg_t cfg;
  logic wr_fbdiv;
  logic [NCPU-1:0] stop_sel;

  ckgen_regfile #(.ADDR_W(ADDR_W), .FSEL_W(FSEL_W), .FSEL_166(FSEL_166)) u_rf (
    .clk(clk), .rst_n(rst_n), .fsel(fsel), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .cfg(cfg), .wr_fbdiv(wr_fbdiv)
  );

  ckgen_rdmux #(.ADDR_W(ADDR_W)) u_rd (.cfg(cfg), .addr(addr), .rdata(rdata));

  ckgen_outgate u_gate (
    .boe(cfg.boe), .stop(cfg.stop), .cpu_stop_n(cpu_stop_n), .buf_oe(buf_oe)
  );

  assign stop_sel  = cfg.stop;
  assign pll_en    = cfg.pll;
  assign div_en    = cfg.div;
  assign ss_en     = cfg.ss;
  assign pll3_fsel = cfg.ss[0] ? cfg.p3sel : 3'b000;
  assign ref_oe    = cfg.ref_en;
  assign ref_slew  = cfg.slew;
  assign fbdiv_n   = cfg.n;
endmodule

// File: rtl/ckgen_ctrl_chk.sv
module ckgen_ctrl_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_stop_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdata,
  input logic [2:0]        pll_en,
  input logic [3:0]        div_en,
  input logic [1:0]        ss_en,
  input logic [2:0]        pll3_fsel,
  input logic [7:0]        buf_oe,
  input logic [1:0]        ref_slew,
  input logic [8:0]        fbdiv_n,
  input logic              wr_fbdiv,
  input logic [2:0]        stop_sel
);
  p_cpu_src_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_en[3] || div_en[2]) |-> pll_en[2]);
  p_lcd_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
    div_en[1] |-> pll_en[0]);
  p_dot_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
    div_en[0] |-> pll_en[1]);
  p_pll3_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_en[0] |-> (pll3_fsel == 3'b000));
  p_cpu0_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stop_n && stop_sel[2]) |-> !buf_oe[7]);
  p_cpu2_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stop_n && stop_sel[0]) |-> !buf_oe[5]);
  p_slew_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_slew != 2'b11);
  p_fbdiv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fbdiv |=> $stable(fbdiv_n));
  p_rsv6_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) == 6) |-> (rdata == 8'hF3));
endmodule

bind ckgen_ctrl_regs ckgen_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .addr(addr),
  .rdata(rdata), .pll_en(pll_en), .div_en(div_en), .ss_en(ss_en),
  .pll3_fsel(pll3_fsel), .buf_oe(buf_oe), .ref_slew(ref_slew),
  .fbdiv_n(fbdiv_n), .wr_fbdiv(wr_fbdiv), .stop_sel(stop_sel)
);

// File: tb/tb_ckgen_ctrl_regs.sv
module tb_ckgen_ctrl_regs;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] fsel = 2'b01;
  logic       cpu_stop_n = 1;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic       wr_en = 0;
  logic [7:0] rdata;
  logic [2:0] pll_en;
  logic [3:0] div_en;
  logic [1:0] ss_en;
  logic [2:0] pll3_fsel;
  logic [7:0] buf_oe;
  logic       ref_oe;
  logic [1:0] ref_slew;
  logic [8:0] fbdiv_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ckgen_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .fsel(fsel), .cpu_stop_n(cpu_stop_n),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rdata(rdata),
    .pll_en(pll_en), .div_en(div_en), .ss_en(ss_en), .pll3_fsel(pll3_fsel),
    .buf_oe(buf_oe), .ref_oe(ref_oe), .ref_slew(ref_slew), .fbdiv_n(fbdiv_n)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    addr = a; #1;
    check(tag, {8'h0, rdata}, {8'h0, exp});
  endtask

  task automatic do_reset(input logic [1:0] fs);
    @(negedge clk); rst_n = 0; fsel = fs;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 reg0", 0, 8'hEF);
    rd_chk("R1 reg1", 1, 8'hC0);
    rd_chk("R1 reg2", 2, 8'hFF);
    rd_chk("R1 reg3", 3, 8'h28);
    check("R2 pll_en reset", 16'(pll_en), 16'h7);
    check("R2 div_en reset", 16'(div_en), 16'hF);
    check("R9 fbdiv 166", 16'(fbdiv_n), 16'h07D);
    rd_chk("R8 reg4 reset", 4, 8'hFE);
    rd_chk("R8 reg5 reset", 5, 8'h7D);
  endtask

  task automatic t_interlock;
    wr(0, 8'h6F);
    rd_chk("R3 pll1 off same write", 0, 8'h63);
    check("R3 div_en pll1 off", 16'(div_en), 16'h3);
    check("R2 pll_en pll1 off", 16'(pll_en), 16'h3);
    wr(0, 8'hE0);
    rd_chk("R3 re-enable keeps divs clear", 0, 8'hE0);
    wr(0, 8'hFF);
    rd_chk("R2 bit4 reserved", 0, 8'hEF);
    wr(0, 8'hAF);
    rd_chk("R3 pll2 off clears dot", 0, 8'hAE);
    wr(0, 8'hCF);
    rd_chk("R3 pll3 off clears lcd", 0, 8'hCD);
    check("R3 div_en pll3 off", 16'(div_en), 16'hD);
  endtask

  task automatic t_spread;
    wr(1, 8'hE8);
    check("R4 pll3_fsel active", 16'(pll3_fsel), 16'h5);
    check("R4 ss_en", 16'(ss_en), 16'h3);
    wr(1, 8'hA8);
    check("R4 pll3_fsel spread off", 16'(pll3_fsel), 16'h0);
    rd_chk("R4 raw select kept", 1, 8'hA8);
    wr(1, 8'hEF);
    rd_chk("R10 reg1 reserved bits", 1, 8'hE8);
  endtask

  task automatic t_buf;
    wr(2, 8'hA5);
    check("R5 buf_oe pattern", 16'(buf_oe), 16'hA5);
    rd_chk("R5 reg2 read", 2, 8'hA5);
  endtask

  task automatic t_stop;
    wr(2, 8'hFF);
    wr(3, 8'h2D);
    #1 check("R6 stop high", 16'(buf_oe), 16'hFF);
    cpu_stop_n = 0; #1;
    check("R6 stop low gates CPU0 CPU2", 16'(buf_oe), 16'h5F);
    wr(3, 8'h2A);
    #1 check("R6 stop low gates CPU1", 16'(buf_oe), 16'hBF);
    cpu_stop_n = 1; #1;
    check("R6 stop released", 16'(buf_oe), 16'hFF);
  endtask

  task automatic t_ref;
    wr(3, 8'h10);
    check("R7 ref off", 16'(ref_oe), 16'h0);
    check("R7 slew fast", 16'(ref_slew), 16'h2);
    wr(3, 8'h38);
    check("R7 slew reserved ignored", 16'(ref_slew), 16'h2);
    rd_chk("R7 reg3 read", 3, 8'h30);
    wr(3, 8'hD0);
    rd_chk("R10 reg3 bits 7:6", 3, 8'h10);
  endtask

  task automatic t_ndiv;
    wr(5, 8'h34);
    wr(4, 8'hFF);
    check("R8 fbdiv 134", 16'(fbdiv_n), 16'h134);
    rd_chk("R8 reg4 high", 4, 8'hFF);
    wr(4, 8'h00);
    check("R8 fbdiv 034", 16'(fbdiv_n), 16'h034);
    wr(2, 8'h00);
    check("R8 fbdiv held", 16'(fbdiv_n), 16'h034);
  endtask

  task automatic t_rsv;
    wr(6, 8'h00);
    rd_chk("R10 reg6", 6, 8'hF3);
    wr(7, 8'hFF);
    rd_chk("R10 reg7", 7, 8'h00);
    check("R10 other state untouched", 16'(fbdiv_n), 16'h034);
  endtask

  task automatic t_fsel;
    do_reset(2'b10);
    fsel = 2'b01; repeat (2) @(negedge clk);
    check("R9 fbdiv other", 16'(fbdiv_n), 16'h064);
    rd_chk("R9 reg5 other", 5, 8'h64);
    do_reset(2'b01);
    check("R9 fbdiv 166 again", 16'(fbdiv_n), 16'h07D);
  endtask

  initial begin
    fork
      begin
        do_reset(2'b01);
        t_reset();
        t_interlock();
        t_spread();
        t_buf();
        t_stop();
        t_ref();
        t_ndiv();
        t_rsv();
        t_fsel();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule